// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital half of a four-input, 12-bit successive-approximation converter whose result leaves as a serial bit stream. It picks the analog input for the external multiplexer, drives the sample-and-hold control, presents a trial code to the external DAC once per clock, and reads back a single comparator bit. From these it builds each result one bit at a time. A finished result is copied into an output latch and shifted out on a single data pin, with a one-clock framing pulse ahead of it.

An active-low select starts and stops all activity. A falling select captures the operating mode. Three modes run: a single conversion sent most-significant bit first, continuous conversion sent least-significant bit first, and continuous conversion sent most-significant bit first. A fourth mode value is rejected. While the select is high, and while the mode is rejected, both serial outputs are released through their enables.

Each conversion takes a 16-clock frame. Phases 0 to 3 sample the input, and phases 4 to 15 each try one bit, starting from bit 11. The result of one frame shifts out during phases 4 to 15 of the following frame.

Top module: `sar_serial_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `sdo_oe`, `samp_oe` and `hold` are 0 and `dac_code` is 0.
- R2: The first clock edge that samples `cs_n` low after having sampled it high starts frame phase 0. From the following cycle `sdo_oe` and `samp_oe` are 1. `hold` is 0 in phases 0 to 3 and 1 in phases 4 to 15, and each frame lasts 16 cycles.
- R3: In phase 4+k the trial code on `dac_code` is the bits already accepted with bit 11-k also set. `cmp_hi` = 1 means the input is at or above the trial code, and the bit is then kept. The result is the largest code not above the input.
- R4: `chan_sel` value n selects input n and is captured into `mux_sel` at each frame's phase 0. `mux_sel` is held for the whole frame, and a change made after phase 0 affects only the next frame.
- R5: `samp` is 1 for exactly one cycle, in phase 14 of each conversion. The first result bit of that conversion is on `sdo` five cycles after `samp` returns to 0. The 12 bits follow on consecutive cycles.
- R6: With `mode_sel` = 00 one conversion is made and sent most-significant bit first. After that `sdo` is 0 with `sdo_oe` = 1, and no further `samp` pulse or `hold` appears until `cs_n` goes high and low again.
- R7: With `mode_sel` = 01 conversions repeat while `cs_n` stays low. Each result is sent least-significant bit first, and the first bit appears on the 20th cycle after the start edge.
- R8: With `mode_sel` = 11 conversions repeat while `cs_n` stays low, and each result is sent most-significant bit first.
- R9: An edge that samples `cs_n` high ends any activity. In the next cycle `sdo_oe`, `samp_oe` and `hold` are 0.
- R10: With `mode_sel` = 10 at the start edge, no conversion runs and both enables stay 0 until `cs_n` goes high.
- R11: `mode_sel` is captured only at the start edge. Changing it while `cs_n` stays low has no effect on bit order or on repetition.
- R12: A result shifting out is not disturbed by the bit trials of the next conversion, which run at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; falling starts, high stops |
| mode_sel | input | 2 | Mode: 00 single MSB-first, 01 continuous LSB-first, 11 continuous MSB-first, 10 rejected |
| chan_sel | input | 2 | Requested analog input |
| cmp_hi | input | 1 | Comparator: input at or above `dac_code` |
| mux_sel | output | 2 | Analog multiplexer select for the running frame |
| hold | output | 1 | Sample-and-hold control, 1 while bits are tried |
| dac_code | output | 12 | Trial code for the DAC |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for `sdo` |
| samp | output | 1 | One-clock framing pulse ahead of each result |
| samp_oe | output | 1 | Output enable for `samp` |

## Verification
The hardest case to reach is a continuous run in which the channel and the analog level both change at a frame boundary. In that case the previous result is still shifting out while the new conversion is trying its bits. The stimulus moves `chan_sel` partway through the first frame and changes the level of the new input only at phase 0 of the second frame. It also flips `mode_sel` after the start. Both results must then arrive intact and in the captured bit order. A behavioural comparator in the bench answers the trial codes, so every expected result is simply the analog value the bench set.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_CONT_LSB = 2'b01,
        MODE_REJECT   = 2'b10,
        MODE_CONT_MSB = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BLOCKED,
        ST_CONV,
        ST_DRAIN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic sampling;
        logic trial;
        logic frame_end;
        logic out_active;
        logic lsb_first;
        logic drive;
        logic samp_pulse;
    } seq_status_t;

    function automatic logic mode_runs(mode_e m);
        return m != MODE_REJECT;
    endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 4,
    parameter int CHAN_W     = 2,
    parameter int PH_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [1:0]        mode_sel,
    input  logic [CHAN_W-1:0] chan_sel,
    output logic [PH_W-1:0]   phase,
    output logic [CHAN_W-1:0] chan_q,
    output seq_status_t       st
);
    localparam int FRAME_CYC = DATA_W + SAMPLE_CYC;
    localparam logic [PH_W-1:0] PH_LAST   = PH_W'(FRAME_CYC - 1);
    localparam logic [PH_W-1:0] PH_TRIAL0 = PH_W'(SAMPLE_CYC);
    // framing pulse placed so data starts six phases later (next frame)
    localparam logic [PH_W-1:0] PH_SAMP   = PH_W'(FRAME_CYC + SAMPLE_CYC - 6);

    logic       cs_q;
    seq_state_e state;
    mode_e      mode_q;
    logic       out_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b0;
            state   <= ST_IDLE;
            phase   <= '0;
            mode_q  <= MODE_ONESHOT;
            chan_q  <= '0;
            out_vld <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                state   <= ST_IDLE;
                phase   <= '0;
                out_vld <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (cs_q) begin
                            mode_q <= mode_e'(mode_sel);
                            phase  <= '0;
                            if (mode_runs(mode_e'(mode_sel))) begin
                                state  <= ST_CONV;
                                chan_q <= chan_sel;
                            end else begin
                                state <= ST_BLOCKED;
                            end
                        end
                    end
                    ST_CONV: begin
                        if (phase == PH_LAST) begin
                            phase   <= '0;
                            out_vld <= 1'b1;
                            if (mode_q == MODE_ONESHOT) state <= ST_DRAIN;
                            else                        chan_q <= chan_sel;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    ST_DRAIN: begin
                        if (phase == PH_LAST) begin
                            phase   <= '0;
                            out_vld <= 1'b0;
                            state   <= ST_DONE;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        st.sampling   = (state == ST_CONV) && (phase < PH_TRIAL0);
        st.trial      = (state == ST_CONV) && (phase >= PH_TRIAL0);
        st.frame_end  = (state == ST_CONV) && (phase == PH_LAST);
        st.out_active = out_vld && ((state == ST_CONV) || (state == ST_DRAIN))
                        && (phase >= PH_TRIAL0);
        st.lsb_first  = (mode_q == MODE_CONT_LSB);
        st.drive      = (state == ST_CONV) || (state == ST_DRAIN) || (state == ST_DONE);
        st.samp_pulse = (state == ST_CONV) && (phase == PH_SAMP);
    end

    p_samp_single_r5: assert property (@(posedge clk) disable iff (rst)
        st.samp_pulse |=> !st.samp_pulse);

    p_deselect_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (state == ST_IDLE));

    p_chan_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONV && phase != '0) |-> $stable(chan_q));

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_q));

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> (!st.trial && !st.samp_pulse && !st.out_active));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 4,
    parameter int PH_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trial,
    input  logic              frame_end,
    input  logic [PH_W-1:0]   phase,
    input  logic              cmp_hi,
    output logic [DATA_W-1:0] dac_code,
    output logic [DATA_W-1:0] result
);
    localparam int FRAME_CYC = DATA_W + SAMPLE_CYC;

    logic [DATA_W-1:0] sar;
    logic [DATA_W-1:0] bit_sel;
    logic [DATA_W-1:0] trial_code;

    // bit i is tried in phase FRAME_CYC-1-i, MSB first
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit_sel
        assign bit_sel[i] = trial && (phase == PH_W'(FRAME_CYC - 1 - i));
    end

    assign trial_code = sar | bit_sel;
    assign dac_code   = trial ? trial_code : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sar    <= '0;
            result <= '0;
        end else begin
            if (!trial)      sar <= '0;
            else if (cmp_hi) sar <= trial_code;
            if (frame_end) result <= cmp_hi ? trial_code : sar;
        end
    end

    p_trial_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        trial |-> ($countones(bit_sel) == 1));

    p_sar_cleared_r3: assert property (@(posedge clk) disable iff (rst)
        (trial && phase == PH_W'(SAMPLE_CYC)) |-> (sar == '0));

    p_latch_stable_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_end) |-> $stable(result));

endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out #(
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 4,
    parameter int PH_W       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] result,
    input  logic [PH_W-1:0]   phase,
    input  logic              out_active,
    input  logic              lsb_first,
    output logic              sdo
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] rev;
    logic [DATA_W-1:0] ordered;
    logic [PH_W-1:0]   offs;
    logic [IDX_W-1:0]  idx;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev[i] = result[DATA_W-1-i];
    end

    assign ordered = lsb_first ? result : rev;
    assign offs    = phase - PH_W'(SAMPLE_CYC);
    assign idx     = offs[IDX_W-1:0];
    assign sdo     = out_active ? ordered[idx] : 1'b0;

    p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_active |-> (offs < PH_W'(DATA_W)));

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int SAMPLE_CYC = 4,
    parameter int CHAN_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [1:0]        mode_sel,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              cmp_hi,
    output logic [CHAN_W-1:0] mux_sel,
    output logic              hold,
    output logic [DATA_W-1:0] dac_code,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              samp,
    output logic              samp_oe
);
    localparam int FRAME_CYC = DATA_W + SAMPLE_CYC;
    localparam int PH_W      = $clog2(FRAME_CYC);

    logic [PH_W-1:0]   phase;
    seq_status_t       st;
    logic [DATA_W-1:0] result;

    sar_seq_ctrl #(
        .DATA_W(DATA_W), .SAMPLE_CYC(SAMPLE_CYC), .CHAN_W(CHAN_W), .PH_W(PH_W)
    ) ctrl_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .mode_sel(mode_sel),
        .chan_sel(chan_sel), .phase(phase), .chan_q(mux_sel), .st(st)
    );

    sar_bit_engine #(
        .DATA_W(DATA_W), .SAMPLE_CYC(SAMPLE_CYC), .PH_W(PH_W)
    ) engine_i (
        .clk(clk), .rst(rst), .trial(st.trial), .frame_end(st.frame_end),
        .phase(phase), .cmp_hi(cmp_hi), .dac_code(dac_code), .result(result)
    );

    sar_serial_out #(
        .DATA_W(DATA_W), .SAMPLE_CYC(SAMPLE_CYC), .PH_W(PH_W)
    ) out_i (
        .clk(clk), .rst(rst), .result(result), .phase(phase),
        .out_active(st.out_active), .lsb_first(st.lsb_first), .sdo(sdo)
    );

    assign hold    = st.trial;
    assign samp    = st.samp_pulse;
    assign sdo_oe  = st.drive;
    assign samp_oe = st.drive;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!sdo_oe && !samp_oe && !hold && dac_code == '0));

    p_released_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> (!hold && !samp && !sdo));

endmodule

// File: tb/sar_serial_seq_tb.sv
`timescale 1ns/1ps
module sar_serial_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n;
    logic [1:0]  mode_sel;
    logic [1:0]  chan_sel;
    logic        cmp_hi;
    logic [1:0]  mux_sel;
    logic        hold;
    logic [11:0] dac_code;
    logic        sdo, sdo_oe, samp, samp_oe;

    logic [11:0] analog [4];
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // behavioural comparator standing in for the analog front end
    assign cmp_hi = (analog[mux_sel] >= dac_code);

    sar_serial_seq dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .mode_sel(mode_sel),
        .chan_sel(chan_sel), .cmp_hi(cmp_hi), .mux_sel(mux_sel), .hold(hold),
        .dac_code(dac_code), .sdo(sdo), .sdo_oe(sdo_oe), .samp(samp),
        .samp_oe(samp_oe)
    );

    // {mode[29:28], chA[27:26], valA[25:14], chB[13:12], valB[11:0]}
    localparam logic [29:0] VECS [8] = '{
        {2'b00, 2'd0, 12'hA5C, 2'd1, 12'h000},
        {2'b00, 2'd3, 12'hFFF, 2'd2, 12'h000},
        {2'b00, 2'd1, 12'h000, 2'd3, 12'h000},
        {2'b01, 2'd1, 12'h123, 2'd3, 12'hFED},
        {2'b11, 2'd2, 12'h800, 2'd0, 12'h7FF},
        {2'b01, 2'd3, 12'h001, 2'd2, 12'h555},
        {2'b11, 2'd0, 12'hC3A, 2'd0, 12'h3C5},
        {2'b11, 2'd1, 12'hFFE, 2'd2, 12'h001}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        tick();
        chk(!sdo_oe && !samp_oe && !hold, "R9 outputs released after deselect",
            {sdo_oe, samp_oe, hold}, 0);
        tick();
    endtask

    task automatic run_case(input logic [29:0] v);
        logic [1:0]  md;
        logic [1:0]  ca, cb;
        logic [11:0] va, vb, got0, got1;
        bit          cont, msb;
        md = v[29:28]; ca = v[27:26]; va = v[25:14]; cb = v[13:12]; vb = v[11:0];
        cont = (md != 2'b00);
        msb  = (md != 2'b01);
        got0 = '0; got1 = '0;
        analog[ca] = va;
        chan_sel = ca;
        mode_sel = md;
        cs_n = 1'b0;
        for (int c = 0; c < 48; c++) begin
            tick();
            if (c == 0) begin
                chk(sdo_oe && samp_oe, "R2 enables on at start", {sdo_oe, samp_oe}, 3);
                chk(mux_sel == ca, "R4 channel captured at start", mux_sel, ca);
                chk(!hold, "R2 sampling in phase 0", hold, 0);
            end
            if (c == 2) mode_sel = (md == 2'b01) ? 2'b11 : (md == 2'b11 ? 2'b01 : 2'b11); // R11
            if (c == 3) chk(!hold, "R2 sampling in phase 3", hold, 0);
            if (c == 4) begin
                chk(hold, "R2 trial begins phase 4", hold, 1);
                chk(dac_code == 12'h800, "R3 first trial code", dac_code, 12'h800);
            end
            if (c == 5) begin
                chan_sel = cb;
                chk(mux_sel == ca, "R4 mid-frame change ignored", mux_sel, ca);
            end
            if (c == 13 || c == 15) chk(!samp, "R5 samp low around pulse", samp, 0);
            if (c == 14) chk(samp, "R5 samp pulse in phase 14", samp, 1);
            if (c == 16) begin
                analog[cb] = vb;
                if (cont) chk(mux_sel == cb, "R4 new channel next frame", mux_sel, cb);
                chk(!hold, "R2 frame restarts at 16 cycles", hold, 0);
            end
            if (c == 19) chk(!sdo, "R5 no data before lead", sdo, 0);
            if (c >= 20 && c < 32) begin
                if (msb) got0[31 - c] = sdo;
                else     got0[c - 20] = sdo;
            end
            if (c == 20) chk(hold == cont, "R6 R8 trials repeat only in continuous modes", hold, cont);
            if (c == 30) chk(samp == cont, "R6 samp repeats only in continuous modes", samp, cont);
            if (c >= 36 && c < 48) begin
                if (msb) got1[47 - c] = sdo;
                else     got1[c - 36] = sdo;
            end
            if (!cont && (c == 35 || c == 47))
                chk(!sdo && sdo_oe && !hold && !samp, "R6 halted with data low",
                    {sdo, sdo_oe, hold, samp}, 4'b0100);
        end
        if (md == 2'b00) chk(got0 == va, "R6 single result MSB first", got0, va);
        if (md == 2'b01) chk(got0 == va, "R7 first result LSB first at cycle 20", got0, va);
        if (md == 2'b11) chk(got0 == va, "R8 first result MSB first", got0, va);
        if (cont) begin
            chk(got1 == vb, "R12 second result intact after overlap", got1, vb);
            chk(got1 == vb, "R11 order kept after mode pin change", got1, vb);
        end
        deselect();
    endtask

    initial begin
        rst = 1'b1; cs_n = 1'b1; mode_sel = 2'b00; chan_sel = 2'b00;
        for (int i = 0; i < 4; i++) analog[i] = '0;
        tick(); tick();
        chk(!sdo_oe && !samp_oe && !hold && dac_code == 0, "R1 reset state",
            {sdo_oe, samp_oe, hold, dac_code}, 0);
        rst = 1'b0;
        tick();
        chk(!sdo_oe && !samp_oe && !hold && dac_code == 0, "R1 state after reset",
            {sdo_oe, samp_oe, hold, dac_code}, 0);
        tick();

        foreach (VECS[k]) run_case(VECS[k]);

        // R10: rejected mode
        mode_sel = 2'b10; chan_sel = 2'd2; cs_n = 1'b0;
        for (int c = 0; c < 24; c++) begin
            tick();
            if (c == 2 || c == 14 || c == 23)
                chk(!sdo_oe && !samp_oe && !hold && !samp, "R10 rejected mode stays released",
                    {sdo_oe, samp_oe, hold, samp}, 0);
        end
        deselect();

        // R9: abort mid-conversion, then restart
        analog[1] = 12'h3A7; mode_sel = 2'b11; chan_sel = 2'd1; cs_n = 1'b0;
        for (int c = 0; c < 9; c++) tick();
        chk(hold, "R9 trial running before abort", hold, 1);
        cs_n = 1'b1;
        tick();
        chk(!sdo_oe && !samp_oe && !hold && dac_code == 0, "R9 abort releases outputs",
            {sdo_oe, samp_oe, hold, dac_code}, 0);
        tick();
        run_case({2'b01, 2'd1, 12'h3A7, 2'd2, 12'h9B6});

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule